// File: doc/BRIEF.md
# Fractional-rate realtime master counter

This block keeps a free-running 64-bit time count whose nominal rate is 6.144 MHz, whatever reference clock drives it. Each reference cycle adds a rational step, numerator over denominator, to the count. A remainder accumulator holds the fraction, so the long-run count is exactly the cycle count times the ratio. When the step is larger than one, a single cycle can add several whole counts.

Software reaches the block through a small register port. It can load the numerator and the denominator directly. It can also ask the block to load a preset ratio that matches the reference frequency named on a rate-select input. A nonzero value on the two strap pins replaces any preset with the ratio for a reference that runs from an emulated low-speed clock.

A slow correction tick, nominally 32.768 kHz, drives a coarse counter. On each tick the fine count is snapped to the value that the coarse count implies. A zero denominator puts the block in an error state that freezes the count. Reading the low half of the count latches the high half, so the two halves of one read always belong together.

Top module: `rtcnt_top`

## Requirements
- R1: After a synchronous reset the count is 0, the ratio is 4/25, the error flag is 0 and the auxiliary field is 0. At address 2 the numerator register reads 0x0000_0004. At address 3 the denominator reads 25, and at address 4 the control register reads 0.
- R2: After a ratio load, with no further writes or ticks, the count after N reference cycles equals floor(N*num/den). This holds for a step above one (3/2 gives 15 after 10 cycles), which adds up to 4 counts in a cycle. With the default 4/25, 100 cycles give 16.
- R3: A control write (address 4) with bit 0 set loads the preset chosen by rate_sel when strap is 0. The presets are: 0 gives 64/125, 1 gives 768/1625, 2 gives 8/25, 3 gives 192/625, 4 gives 384/1625, 5 gives 256/1125, and 6 or 7 gives 4/25. At 64/125, 250 cycles give 128.
- R4: When either strap bit is 1, a preset load gives 75/244 whatever rate_sel is. At that ratio, 488 cycles give 150.
- R5: A coarse_tick pulse advances the coarse counter to k and sets the count to floor(k*375/2) at that edge. It also clears the remainder, so the first tick gives 187 and the second gives 375. Counting resumes from that value.
- R6: A write to the numerator register (address 2) changes only bits [15:0]. Bits [31:16] hold the auxiliary field, which stays as it was. Only a control write sets the auxiliary field, from wdata[31:16], and a control write with bit 0 clear loads no ratio.
- R7: Writing 0 to the denominator sets the error flag, which appears on err and on bit 0 of the control register. While the flag is set, the count holds and ticks are ignored. Writing a nonzero denominator clears the flag, and counting resumes from the held value with a cleared remainder.
- R8: A numerator, denominator or preset write holds the count at its own edge and clears the remainder. The new ratio applies from the next cycle.
- R9: The count wraps from all ones to 0. A read of address 0 returns count[31:0] and latches count[63:32] at that edge. Address 1 returns the latched half, even if the count has moved on since.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 3 | Reference-frequency code used by a preset load |
| strap | input | 2 | Strap pins; nonzero forces the fallback ratio |
| coarse_tick | input | 1 | One-cycle pulse from the low-frequency correction tick |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (latches the high half on address 0) |
| addr | input | 3 | Register address: 0 count low, 1 latched high, 2 numerator, 3 denominator, 4 control |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| err | output | 1 | Zero-denominator error flag |

## Verification
Read data is combinational, so the bench samples it one time unit after a falling edge, in the same cycle that the address is presented. Writes, ticks and ratio loads act at the rising edge inside their strobe, and the count then moves at each later rising edge. Every expected count is therefore floor(N*num/den), where N is the number of rising edges that the bench has counted since the last write or tick, and each read task uses up exactly one edge. The high-half latch is checked one edge after the low-half read, at a point where the count has already wrapped, so that a stale or live high half would show.

// File: rtl/rtcnt_pkg.sv
package rtcnt_pkg;

   typedef enum logic [2:0] {
      RATE_12M   = 3'd0,
      RATE_13M   = 3'd1,
      RATE_19M2  = 3'd2,
      RATE_20M   = 3'd3,
      RATE_26M   = 3'd4,
      RATE_27M   = 3'd5,
      RATE_38M4  = 3'd6,
      RATE_OTHER = 3'd7
   } rate_e;

   localparam logic [2:0] ADDR_CNT_LO = 3'd0;
   localparam logic [2:0] ADDR_CNT_HI = 3'd1;
   localparam logic [2:0] ADDR_NUM    = 3'd2;
   localparam logic [2:0] ADDR_DEN    = 3'd3;
   localparam logic [2:0] ADDR_CTRL   = 3'd4;

   localparam int DEF_NUM = 4;
   localparam int DEF_DEN = 25;
   localparam int FB_NUM  = 75;
   localparam int FB_DEN  = 244;

endpackage

// File: rtl/rtcnt_ratio_sel.sv
module rtcnt_ratio_sel
   import rtcnt_pkg::*;
#(
   parameter int NUM_W = 16,
   parameter int DEN_W = 16
) (
   input  logic [2:0]       rate_sel,
   input  logic [1:0]       strap,
   output logic [NUM_W-1:0] preset_num,
   output logic [DEN_W-1:0] preset_den
);

   always_comb begin
      if (strap != 2'b00) begin
         preset_num = NUM_W'(FB_NUM);
         preset_den = DEN_W'(FB_DEN);
      end else begin
         case (rate_e'(rate_sel))
            RATE_12M:  begin preset_num = NUM_W'(64);  preset_den = DEN_W'(125);  end
            RATE_13M:  begin preset_num = NUM_W'(768); preset_den = DEN_W'(1625); end
            RATE_19M2: begin preset_num = NUM_W'(8);   preset_den = DEN_W'(25);   end
            RATE_20M:  begin preset_num = NUM_W'(192); preset_den = DEN_W'(625);  end
            RATE_26M:  begin preset_num = NUM_W'(384); preset_den = DEN_W'(1625); end
            RATE_27M:  begin preset_num = NUM_W'(256); preset_den = DEN_W'(1125); end
            default:   begin preset_num = NUM_W'(DEF_NUM); preset_den = DEN_W'(DEF_DEN); end
         endcase
      end
   end

endmodule

// File: rtl/rtcnt_frac_acc.sv
module rtcnt_frac_acc #(
   parameter int NUM_W     = 16,
   parameter int DEN_W     = 16,
   parameter int ACC_W     = 18,
   parameter int MAX_CARRY = 4,
   parameter int CW        = 3
) (
   input  logic [ACC_W-1:0] acc_q,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic [ACC_W-1:0] acc_d,
   output logic [CW-1:0]    carries
);

   logic [ACC_W-1:0]     stage [MAX_CARRY+1];
   logic [MAX_CARRY-1:0] hit;

   assign stage[0] = acc_q + ACC_W'(num);

   for (genvar i = 0; i < MAX_CARRY; i++) begin : g_carry
      assign hit[i]       = (den != '0) && (stage[i] >= ACC_W'(den));
      assign stage[i+1]   = hit[i] ? (stage[i] - ACC_W'(den)) : stage[i];
   end

   assign acc_d = stage[MAX_CARRY];

   always_comb begin
      carries = '0;
      for (int k = 0; k < MAX_CARRY; k++) begin
         carries = carries + CW'(hit[k]);
      end
   end

endmodule

// File: rtl/rtcnt_regs.sv
module rtcnt_regs
   import rtcnt_pkg::*;
#(
   parameter int CNT_W = 64,
   parameter int NUM_W = 16,
   parameter int DEN_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [2:0]       addr,
   input  logic [31:0]      wdata,
   input  logic [CNT_W-1:0] count,
   input  logic [NUM_W-1:0] preset_num,
   input  logic [DEN_W-1:0] preset_den,
   output logic [NUM_W-1:0] num_q,
   output logic [DEN_W-1:0] den_q,
   output logic             err_q,
   output logic             ratio_wr,
   output logic [31:0]      rdata
);

   localparam int AUX_W = 32 - NUM_W;

   logic [AUX_W-1:0] aux_q;
   logic [31:0]      hi_q;
   logic             wr_num, wr_den, wr_ctrl;

   assign wr_num   = wr_en && (addr == ADDR_NUM);
   assign wr_den   = wr_en && (addr == ADDR_DEN);
   assign wr_ctrl  = wr_en && (addr == ADDR_CTRL);
   assign ratio_wr = wr_num || wr_den || (wr_ctrl && wdata[0]);

   always_ff @(posedge clk) begin
      if (rst) begin
         num_q <= NUM_W'(DEF_NUM);
         den_q <= DEN_W'(DEF_DEN);
         err_q <= 1'b0;
         aux_q <= '0;
         hi_q  <= '0;
      end else begin
         if (wr_num) begin
            num_q <= wdata[NUM_W-1:0];
         end
         if (wr_den) begin
            den_q <= wdata[DEN_W-1:0];
            err_q <= (wdata[DEN_W-1:0] == '0);
         end
         if (wr_ctrl) begin
            aux_q <= wdata[31:NUM_W];
            if (wdata[0]) begin
               num_q <= preset_num;
               den_q <= preset_den;
               err_q <= 1'b0;
            end
         end
         if (rd_en && (addr == ADDR_CNT_LO)) begin
            hi_q <= count[63:32];
         end
      end
   end

   always_comb begin
      case (addr)
         ADDR_CNT_LO: rdata = count[31:0];
         ADDR_CNT_HI: rdata = hi_q;
         ADDR_NUM:    rdata = {aux_q, num_q};
         ADDR_DEN:    rdata = 32'(den_q);
         ADDR_CTRL:   rdata = {aux_q, {(NUM_W-1){1'b0}}, err_q};
         default:     rdata = '0;
      endcase
   end

   // R6: a numerator write leaves the auxiliary field alone
   p_num_keeps_aux_r6: assert property (@(posedge clk) disable iff (rst)
      wr_num |=> (aux_q == $past(aux_q)));

   // R7: a zero denominator raises the error flag
   p_den_zero_err_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_den && (wdata[DEN_W-1:0] == '0)) |=> err_q);

endmodule

// File: rtl/rtcnt_top.sv
module rtcnt_top #(
   parameter int          CNT_W      = 64,
   parameter int          NUM_W      = 16,
   parameter int          DEN_W      = 16,
   parameter int          MAX_CARRY  = 4,
   parameter int          COARSE_W   = 48,
   parameter logic [63:0] TICK_GAIN  = 64'd375,
   parameter int          TICK_SHIFT = 1
) (
   input  logic        clk,
   input  logic        rst,
   input  logic [2:0]  rate_sel,
   input  logic [1:0]  strap,
   input  logic        coarse_tick,
   input  logic        wr_en,
   input  logic        rd_en,
   input  logic [2:0]  addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        err
);

   localparam int ACC_W = ((NUM_W > DEN_W) ? NUM_W : DEN_W) + 2;
   localparam int CW    = $clog2(MAX_CARRY + 1);
   localparam int PW    = CNT_W + TICK_SHIFT;

   if (CNT_W != 64) begin : g_bad_cnt
      $error("rtcnt_top: CNT_W must be 64");
   end
   if (NUM_W < 11 || NUM_W > 31) begin : g_bad_num
      $error("rtcnt_top: NUM_W must be 11..31");
   end
   if (DEN_W < 11 || DEN_W > 32) begin : g_bad_den
      $error("rtcnt_top: DEN_W must be 11..32");
   end
   if (MAX_CARRY < 1) begin : g_bad_carry
      $error("rtcnt_top: MAX_CARRY must be at least 1");
   end
   if (COARSE_W < 1 || COARSE_W > CNT_W) begin : g_bad_coarse
      $error("rtcnt_top: COARSE_W must be 1..CNT_W");
   end

   logic [CNT_W-1:0]    count_q, snap;
   logic [ACC_W-1:0]    acc_q, acc_d;
   logic [COARSE_W-1:0] coarse_q, coarse_next;
   logic [NUM_W-1:0]    num_q, preset_num;
   logic [DEN_W-1:0]    den_q, preset_den;
   logic [CW-1:0]       carries;
   logic                err_q, ratio_wr;

   rtcnt_ratio_sel #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_sel (
      .rate_sel   (rate_sel),
      .strap      (strap),
      .preset_num (preset_num),
      .preset_den (preset_den)
   );

   rtcnt_frac_acc #(
      .NUM_W(NUM_W), .DEN_W(DEN_W), .ACC_W(ACC_W),
      .MAX_CARRY(MAX_CARRY), .CW(CW)
   ) u_acc (
      .acc_q   (acc_q),
      .num     (num_q),
      .den     (den_q),
      .acc_d   (acc_d),
      .carries (carries)
   );

   rtcnt_regs #(.CNT_W(CNT_W), .NUM_W(NUM_W), .DEN_W(DEN_W)) u_regs (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .addr       (addr),
      .wdata      (wdata),
      .count      (count_q),
      .preset_num (preset_num),
      .preset_den (preset_den),
      .num_q      (num_q),
      .den_q      (den_q),
      .err_q      (err_q),
      .ratio_wr   (ratio_wr),
      .rdata      (rdata)
   );

   assign coarse_next = coarse_q + COARSE_W'(1);

   always_comb begin
      snap = CNT_W'((PW'(coarse_next) * PW'(TICK_GAIN)) >> TICK_SHIFT);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         count_q  <= '0;
         acc_q    <= '0;
         coarse_q <= '0;
      end else if (ratio_wr) begin
         acc_q <= '0;
      end else if (err_q) begin
         acc_q <= acc_q;
      end else if (coarse_tick) begin
         coarse_q <= coarse_next;
         count_q  <= snap;
         acc_q    <= '0;
      end else begin
         count_q <= count_q + CNT_W'(carries);
         acc_q   <= acc_d;
      end
   end

   assign err = err_q;

   // R7: while in error and without a ratio write, the count is frozen
   p_err_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (err_q && !ratio_wr) |=> (count_q == $past(count_q)));

   // R8: a ratio write holds the count at its own edge
   p_write_holds_r8: assert property (@(posedge clk) disable iff (rst)
      ratio_wr |=> (count_q == $past(count_q)));

   // R2: the remainder stays below the denominator whenever the ratio is valid
   p_acc_below_den_r2: assert property (@(posedge clk) disable iff (rst)
      !err_q |-> (acc_q < ACC_W'(den_q)));

   // R2: one plain cycle never adds more than MAX_CARRY counts
   p_step_bound_r2: assert property (@(posedge clk) disable iff (rst)
      (!err_q && !ratio_wr && !coarse_tick) |=>
         ((count_q - $past(count_q)) <= CNT_W'(MAX_CARRY)));

endmodule

// File: tb/rtcnt_top_tb.sv
module rtcnt_top_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  rate_sel = 3'd0;
   logic [1:0]  strap = 2'b00;
   logic        coarse_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [31:0] wdata = 32'd0;
   logic [31:0] rdata, rdata_w;
   logic        err, err_w;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   rtcnt_top u_dut (
      .clk(clk), .rst(rst), .rate_sel(rate_sel), .strap(strap),
      .coarse_tick(coarse_tick), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .err(err)
   );

   rtcnt_top #(.TICK_GAIN(64'hFFFF_FFFF_FFFF_FFFF), .TICK_SHIFT(0)) u_dut_wrap (
      .clk(clk), .rst(rst), .rate_sel(rate_sel), .strap(strap),
      .coarse_tick(coarse_tick), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata_w), .err(err_w)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wr_en = 1'b1;
      addr  = a;
      wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v, output logic [31:0] vw);
      rd_en = 1'b1;
      addr  = a;
      #1;
      v  = rdata;
      vw = rdata_w;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_tick();
      coarse_tick = 1'b1;
      @(negedge clk);
      coarse_tick = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v, vw;
      do_reset();
      rd(3'd0, v, vw); chk("R1 count", v, 32'd0);
      rd(3'd2, v, vw); chk("R1 num", v, 32'h0000_0004);
      rd(3'd3, v, vw); chk("R1 den", v, 32'd25);
      rd(3'd4, v, vw); chk("R1 ctrl", v, 32'd0);
      chk("R1 err pin", {31'd0, err}, 32'd0);
   endtask

   task automatic t_frac();
      logic [31:0] v, vw;
      do_reset();
      idle(100);
      rd(3'd0, v, vw); chk("R2 default 100 cycles", v, 32'd16);
      do_reset();
      wr(3'd2, 32'd3);
      wr(3'd3, 32'd2);
      idle(10);
      rd(3'd0, v, vw); chk("R2 ratio 3/2 multi-carry", v, 32'd15);
   endtask

   task automatic t_ratio_change();
      logic [31:0] v, vw;
      do_reset();
      idle(10);
      wr(3'd2, 32'd1);
      idle(24);
      rd(3'd0, v, vw); chk("R8 remainder cleared", v, 32'd1);
      rd(3'd0, v, vw); chk("R8 new ratio applies", v, 32'd2);
   endtask

   task automatic t_presets();
      logic [31:0] v, vw;
      int exp_num [8] = '{64, 768, 8, 192, 384, 256, 4, 4};
      int exp_den [8] = '{125, 1625, 25, 625, 1625, 1125, 25, 25};
      do_reset();
      strap = 2'b00;
      for (int c = 0; c < 8; c++) begin
         rate_sel = 3'(c);
         wr(3'd4, 32'd1);
         rd(3'd2, v, vw); chk("R3 preset num", v, 32'(exp_num[c]));
         rd(3'd3, v, vw); chk("R3 preset den", v, 32'(exp_den[c]));
      end
      do_reset();
      rate_sel = 3'd0;
      wr(3'd4, 32'd1);
      idle(250);
      rd(3'd0, v, vw); chk("R3 rate 64/125", v, 32'd128);
   endtask

   task automatic t_strap();
      logic [31:0] v, vw;
      do_reset();
      strap = 2'b10;
      rate_sel = 3'd6;
      wr(3'd4, 32'd1);
      rd(3'd2, v, vw); chk("R4 strap num", v, 32'd75);
      rd(3'd3, v, vw); chk("R4 strap den", v, 32'd244);
      idle(486);
      rd(3'd0, v, vw); chk("R4 rate 75/244", v, 32'd150);
      strap = 2'b01;
      rate_sel = 3'd0;
      wr(3'd4, 32'd1);
      rd(3'd2, v, vw); chk("R4 other strap bit", v, 32'd75);
      strap = 2'b00;
   endtask

   task automatic t_tick();
      logic [31:0] v, vw;
      do_reset();
      idle(50);
      pulse_tick();
      rd(3'd0, v, vw); chk("R5 first tick snap", v, 32'd187);
      idle(24);
      rd(3'd0, v, vw); chk("R5 resumes after snap", v, 32'd191);
      pulse_tick();
      rd(3'd0, v, vw); chk("R5 second tick snap", v, 32'd375);
   endtask

   task automatic t_rmw();
      logic [31:0] v, vw;
      do_reset();
      wr(3'd4, 32'hABCD_0000);
      rd(3'd2, v, vw); chk("R6 ctrl without load keeps num", v, 32'hABCD_0004);
      wr(3'd2, 32'h1234_0040);
      rd(3'd2, v, vw); chk("R6 num write keeps aux", v, 32'hABCD_0040);
      rd(3'd4, v, vw); chk("R6 ctrl aux readback", v, 32'hABCD_0000);
   endtask

   task automatic t_err();
      logic [31:0] v, vw;
      do_reset();
      idle(50);
      wr(3'd3, 32'd0);
      rd(3'd4, v, vw); chk("R7 error bit set", v, 32'd1);
      chk("R7 err pin set", {31'd0, err}, 32'd1);
      rd(3'd0, v, vw); chk("R7 count held", v, 32'd8);
      pulse_tick();
      idle(30);
      rd(3'd0, v, vw); chk("R7 tick ignored in error", v, 32'd8);
      wr(3'd3, 32'd25);
      rd(3'd4, v, vw); chk("R7 error cleared", v, 32'd0);
      idle(24);
      rd(3'd0, v, vw); chk("R7 counting resumes", v, 32'd12);
   endtask

   task automatic t_wrap();
      logic [31:0] v, vw;
      do_reset();
      pulse_tick();
      idle(6);
      rd(3'd0, v, vw); chk("R9 low at all ones", vw, 32'hFFFF_FFFF);
      rd(3'd1, v, vw); chk("R9 high latched consistent", vw, 32'hFFFF_FFFF);
      rd(3'd0, v, vw); chk("R9 wrapped to zero", vw, 32'd0);
      rd(3'd1, v, vw); chk("R9 high after wrap", vw, 32'd0);
   endtask

   initial begin
      t_reset();
      t_frac();
      t_ratio_change();
      t_presets();
      t_strap();
      t_tick();
      t_rmw();
      t_err();
      t_wrap();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule